// File: doc/BRIEF.md
# Target Idle and Wakeup Handshake Controller

This block runs the clock-gating handshake between a power manager and one memory-mapped target. A manager state machine watches an idle-conditions input. When the conditions hold, it raises an idle request toward the target. A target-side agent answers that request according to a 2-bit idle-mode setting. In smart-idle mode it waits for the target's work to drain. In force-idle mode it answers at once. In no-idle mode it never answers. Only an answered request lets the manager switch the target's interface clock off.

While the target is gated, an asynchronous wake event returns it to service. So does a direct clock request from the target itself, when the target is marked wakeup-capable. Both inputs pass through a two-flop synchronizer. The manager turns the clocks back on first, then raises a wakeup request, and goes active once the agent acknowledges it. The functional clock can be kept running through the gated period, so the target can still raise interrupts or DMA requests. A forced acknowledge given while the target was busy sets a sticky flag, because work may have been cut short.

Top module: `pwr_idle_hs`

## Requirements
- R1: From the active state with both acknowledges low, `idle_req` rises on the clock edge after `idle_ok` is sampled high, and never rises without it.
- R2: In smart-idle mode (`mode` = 2'b10), `idle_ack` stays low while `mod_busy` is high. It rises on the edge after `idle_req` is high with `mod_busy` low.
- R3: In force-idle mode (`mode` = 2'b00), `idle_ack` rises on the edge after `idle_req` is high, whatever `mod_busy` is.
- R4: In no-idle mode (`mode` = 2'b01, and also 2'b11), `idle_ack` never rises and `iclk_en` stays high for as long as `idle_req` is held.
- R5: `iclk_en` falls on the edge after `idle_ack` is sampled high, and never without it. It stays low until a wakeup starts.
- R6: If `idle_ok` is low while `idle_req` is high and `idle_ack` is still low, `idle_req` falls on the next edge and `iclk_en` stays high.
- R7: While gated, a `wake_evt` held high becomes visible after the two-flop synchronizer. On the third edge after it is applied, `iclk_en` and `wake_req` go high together and `idle_req` goes low. `wake_ack` follows one edge later, and `wake_req` drops one edge after that.
- R8: While gated, `clk_req` starts the same wakeup sequence as R7 when `wake_cap` is 1. When `wake_cap` is 0 it has no effect and `iclk_en` stays low.
- R9: `fclk_en` is high whenever `iclk_en` is high. While gated it equals `fclk_keep`.
- R10: `lost_flag` is set when a force-idle acknowledge is given while `mod_busy` is high. It stays set until `lost_clr` is sampled high. A new set wins over a clear in the same cycle.
- R11: After reset, `idle_req`, `idle_ack`, `wake_req`, `wake_ack` and `lost_flag` are 0, and `iclk_en` and `fclk_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Manager clock |
| rst_n | input | 1 | Active-low reset |
| idle_ok | input | 1 | Target meets its idle conditions |
| mode | input | 2 | Idle mode: 00 force, 01 none, 10 smart, 11 none |
| mod_busy | input | 1 | Target has operations in progress |
| wake_evt | input | 1 | Asynchronous wake event |
| clk_req | input | 1 | Asynchronous clock request from the target |
| wake_cap | input | 1 | Target may wake itself with `clk_req` |
| fclk_keep | input | 1 | Keep the functional clock while gated |
| lost_clr | input | 1 | Clears `lost_flag` |
| idle_req | output | 1 | Idle request to the target |
| idle_ack | output | 1 | Idle acknowledge from the target agent |
| wake_req | output | 1 | Wakeup request to the target |
| wake_ack | output | 1 | Wakeup acknowledge from the target agent |
| iclk_en | output | 1 | Interface clock enable |
| fclk_en | output | 1 | Functional clock enable |
| lost_flag | output | 1 | Sticky: forced idle cut off busy work |

## Verification
The bench walks every mode encoding with the target both busy and free. A design that acknowledged in smart-idle mode while busy, or that treated code 11 as force-idle, would gate the clock at a point where the bench expects it to keep running. Directed cases withdraw the idle conditions before the acknowledge arrives; a design that gated the clocks anyway would show `iclk_en` low. They also time the wake path edge by edge, so a missing or extra synchronizer stage shows up one cycle off. Further cases send a clock request from a target that is not wakeup-capable, which must leave it gated, and check that the lost-activity flag survives until it is cleared.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    MS_ACTIVE = 2'd0,
    MS_REQ    = 2'd1,
    MS_GATED  = 2'd2,
    MS_WAKING = 2'd3
  } mgr_state_e;

  localparam logic [MODE_W-1:0] MODE_FORCE = 2'b00;
  localparam logic [MODE_W-1:0] MODE_SMART = 2'b10;

  function automatic logic mode_is_force(input logic [MODE_W-1:0] m);
    return m == MODE_FORCE;
  endfunction

  // No-idle covers both 01 and 11: neither ever answers.
  function automatic logic ack_allowed(input logic [MODE_W-1:0] m,
                                       input logic busy);
    return mode_is_force(m) || ((m == MODE_SMART) && !busy);
  endfunction

endpackage

// File: rtl/pwr_sync_ff.sv
module pwr_sync_ff #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_idle_mgr.sv
module pwr_idle_mgr
  import pwr_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_ok,
  input  logic idle_ack,
  input  logic wake_ack,
  input  logic wake_trig,
  output logic idle_req,
  output logic wake_req,
  output logic clk_on
);

  mgr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MS_ACTIVE: if (idle_ok && !idle_ack && !wake_ack) state_d = MS_REQ;
      MS_REQ: begin
        if (idle_ack)      state_d = MS_GATED;
        else if (!idle_ok) state_d = MS_ACTIVE;
      end
      MS_GATED:  if (wake_trig) state_d = MS_WAKING;
      MS_WAKING: if (wake_ack)  state_d = MS_ACTIVE;
      default:   state_d = MS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_ACTIVE;
    else        state_q <= state_d;
  end

  assign idle_req = (state_q == MS_REQ) || (state_q == MS_GATED);
  assign wake_req = (state_q == MS_WAKING);
  assign clk_on   = (state_q != MS_GATED);

endmodule

// File: rtl/pwr_idle_agent.sv
module pwr_idle_agent
  import pwr_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              mod_busy,
  input  logic              idle_req,
  input  logic              wake_req,
  input  logic              lost_clr,
  output logic              idle_ack,
  output logic              wake_ack,
  output logic              lost_flag
);

  logic ack_d;
  logic forced_busy;

  assign ack_d       = idle_req && ack_allowed(mode, mod_busy);
  assign forced_busy = idle_req && !idle_ack && mode_is_force(mode) && mod_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ack  <= 1'b0;
      wake_ack  <= 1'b0;
      lost_flag <= 1'b0;
    end else begin
      idle_ack <= ack_d;
      wake_ack <= wake_req;
      if (forced_busy)   lost_flag <= 1'b1;
      else if (lost_clr) lost_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_idle_hs.sv
module pwr_idle_hs
  import pwr_idle_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_ok,
  input  logic [MODE_W-1:0] mode,
  input  logic              mod_busy,
  input  logic              wake_evt,
  input  logic              clk_req,
  input  logic              wake_cap,
  input  logic              fclk_keep,
  input  logic              lost_clr,
  output logic              idle_req,
  output logic              idle_ack,
  output logic              wake_req,
  output logic              wake_ack,
  output logic              iclk_en,
  output logic              fclk_en,
  output logic              lost_flag
);

  localparam int ASYNC_W = 2;

  logic [ASYNC_W-1:0] async_raw;
  logic [ASYNC_W-1:0] async_sync;
  logic               wake_trig;
  logic               clk_on;

  assign async_raw = {clk_req, wake_evt};

  pwr_sync_ff #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_raw),
    .q     (async_sync)
  );

  assign wake_trig = async_sync[0] || (async_sync[1] && wake_cap);

  pwr_idle_mgr u_mgr (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_ok   (idle_ok),
    .idle_ack  (idle_ack),
    .wake_ack  (wake_ack),
    .wake_trig (wake_trig),
    .idle_req  (idle_req),
    .wake_req  (wake_req),
    .clk_on    (clk_on)
  );

  pwr_idle_agent u_agent (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mod_busy  (mod_busy),
    .idle_req  (idle_req),
    .wake_req  (wake_req),
    .lost_clr  (lost_clr),
    .idle_ack  (idle_ack),
    .wake_ack  (wake_ack),
    .lost_flag (lost_flag)
  );

  assign iclk_en = clk_on;
  assign fclk_en = clk_on || fclk_keep;

endmodule

// File: rtl/pwr_idle_hs_chk.sv
module pwr_idle_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_ok,
  input logic [1:0] mode,
  input logic       mod_busy,
  input logic       idle_req,
  input logic       idle_ack,
  input logic       wake_req,
  input logic       wake_ack,
  input logic       iclk_en,
  input logic       lost_flag
);

  a_r1_req_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_req) |-> $past(idle_ok));

  a_r2_smart_waits_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !idle_ack && mode == 2'b10 && mod_busy) |=> !idle_ack);

  a_r3_force_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && mode == 2'b00) |=> idle_ack);

  a_r4_none_never_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !idle_ack && mode[0]) |=> !idle_ack);

  a_r5_gate_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iclk_en) |-> $past(idle_ack));

  a_r7_wake_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> (iclk_en && !idle_req));

  a_r7_wake_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_ack) |-> $past(wake_req));

  a_r10_lost_on_forced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_flag) |-> (idle_ack && $past(mod_busy)));

endmodule

bind pwr_idle_hs pwr_idle_hs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle_ok   (idle_ok),
  .mode      (mode),
  .mod_busy  (mod_busy),
  .idle_req  (idle_req),
  .idle_ack  (idle_ack),
  .wake_req  (wake_req),
  .wake_ack  (wake_ack),
  .iclk_en   (iclk_en),
  .lost_flag (lost_flag)
);

// File: tb/pwr_idle_hs_tb.sv
module pwr_idle_hs_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_ok = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       mod_busy = 1'b0;
  logic       wake_evt = 1'b0;
  logic       clk_req = 1'b0;
  logic       wake_cap = 1'b0;
  logic       fclk_keep = 1'b0;
  logic       lost_clr = 1'b0;
  logic       idle_req, idle_ack, wake_req, wake_ack;
  logic       iclk_en, fclk_en, lost_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_idle_hs u_dut (
    .clk(clk), .rst_n(rst_n), .idle_ok(idle_ok), .mode(mode),
    .mod_busy(mod_busy), .wake_evt(wake_evt), .clk_req(clk_req),
    .wake_cap(wake_cap), .fclk_keep(fclk_keep), .lost_clr(lost_clr),
    .idle_req(idle_req), .idle_ack(idle_ack), .wake_req(wake_req),
    .wake_ack(wake_ack), .iclk_en(iclk_en), .fclk_en(fclk_en),
    .lost_flag(lost_flag)
  );

  // {mode[1:0], busy, expected acknowledge}
  localparam logic [3:0] VEC [6] = '{
    4'b00_0_1, 4'b00_1_1, 4'b01_0_0, 4'b11_0_0, 4'b10_0_1, 4'b10_1_0
  };

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle_ok = 1'b0; mode = 2'b00; mod_busy = 1'b0;
    wake_evt = 1'b0; clk_req = 1'b0; wake_cap = 1'b0;
    fclk_keep = 1'b0; lost_clr = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11 reset values
    do_reset();
    check("R11 idle_req", idle_req, 0);
    check("R11 idle_ack", idle_ack, 0);
    check("R11 wake_req", wake_req, 0);
    check("R11 wake_ack", wake_ack, 0);
    check("R11 lost_flag", lost_flag, 0);
    check("R11 iclk_en", iclk_en, 1);
    check("R11 fclk_en", fclk_en, 1);

    // Table walk over every mode encoding, busy and free
    for (int i = 0; i < 6; i++) begin
      logic exp_ack;
      logic exp_lost;
      do_reset();
      mode = VEC[i][3:2];
      mod_busy = VEC[i][1];
      exp_ack = VEC[i][0];
      exp_lost = (VEC[i][3:2] == 2'b00) && VEC[i][1];
      idle_ok = 1'b1;
      tick();
      check("R1 req after ok", idle_req, 1);
      check("R1 no early ack", idle_ack, 0);
      tick();
      check("R2/R3/R4 ack by mode", idle_ack, exp_ack);
      check("R10 lost by mode", lost_flag, exp_lost);
      tick();
      check("R5 gate after ack", iclk_en, !exp_ack);
      check("R9 fclk follows gate", fclk_en, !exp_ack);
    end

    // R2 smart-idle drains, then R9 keep functional clock, then R7 wake
    do_reset();
    mode = 2'b10; mod_busy = 1'b1; fclk_keep = 1'b1; idle_ok = 1'b1;
    tick(3);
    check("R2 busy holds ack", idle_ack, 0);
    check("R2 clocks on while busy", iclk_en, 1);
    mod_busy = 1'b0;
    tick();
    check("R2 ack after drain", idle_ack, 1);
    tick();
    check("R5 gated", iclk_en, 0);
    check("R9 fclk kept", fclk_en, 1);
    tick(3);
    check("R5 stays gated", iclk_en, 0);
    wake_evt = 1'b1;
    tick(2);
    check("R7 sync latency", iclk_en, 0);
    tick();
    check("R7 clocks back", iclk_en, 1);
    check("R7 wake_req", wake_req, 1);
    check("R7 idle_req dropped", idle_req, 0);
    wake_evt = 1'b0; idle_ok = 1'b0;
    tick();
    check("R7 wake_ack", wake_ack, 1);
    tick();
    check("R7 wake_req done", wake_req, 0);
    check("R7 active clocks", iclk_en, 1);

    // R6 idle conditions withdrawn before acknowledge
    do_reset();
    mode = 2'b01; idle_ok = 1'b1;
    tick();
    check("R6 req raised", idle_req, 1);
    idle_ok = 1'b0;
    tick();
    check("R6 req withdrawn", idle_req, 0);
    check("R6 clocks stay", iclk_en, 1);

    // R4 no-idle held for a long stretch
    do_reset();
    mode = 2'b11; idle_ok = 1'b1;
    begin
      int drops = 0;
      for (int k = 0; k < 40; k++) begin
        tick();
        if (!iclk_en || idle_ack) drops++;
      end
      check("R4 never gated", drops, 0);
      check("R4 req held", idle_req, 1);
    end

    // R8 clock request from the target
    do_reset();
    mode = 2'b00; idle_ok = 1'b1;
    tick(3);
    check("R8 gated", iclk_en, 0);
    idle_ok = 1'b0; wake_cap = 1'b0; clk_req = 1'b1;
    tick(6);
    check("R8 not capable ignored", iclk_en, 0);
    check("R8 not capable no wake", wake_req, 0);
    wake_cap = 1'b1;
    tick();
    check("R8 capable wake", wake_req, 1);
    check("R8 capable clocks", iclk_en, 1);
    clk_req = 1'b0;
    tick();
    check("R8 wake_ack", wake_ack, 1);

    // R10 sticky lost flag and its clear
    do_reset();
    mode = 2'b00; mod_busy = 1'b1; idle_ok = 1'b1;
    tick(2);
    check("R10 lost set", lost_flag, 1);
    mod_busy = 1'b0;
    tick(4);
    check("R10 lost sticky", lost_flag, 1);
    lost_clr = 1'b1;
    tick();
    check("R10 lost cleared", lost_flag, 0);
    lost_clr = 1'b0;

    finish_run();
  end

endmodule